// File: doc/BRIEF.md
# Multi-policy software register field

This block is a register field whose bits each follow their own software access rule. The rule for every bit is fixed at build time by a 4-bit policy code held in a parameter vector. The parameter vector also fixes the reset value of every bit. Software reaches the field through a write strobe with write data, and through a read strobe with read data. Hardware can force bits to 1 through a per-bit set input. The block also raises per-bit one-cycle event pulses when software writes 1 to a trigger bit.

The stored value of every bit is also driven on a hardware-side output. Logic around the field uses it, and it shows the state of bits whose software read view is masked. Writes and hardware sets take effect on the clock edge that samples them. A read returns the value held before the read, and any read side effect lands on the following edge. Address decoding, bus protocol handling and interrupt collection are left to the surrounding logic.

Top module: `swreg_field`

## Requirements
- R1: After reset every bit of `field_q` equals its `RESET_VAL` bit, `evt_out` is 0, and `rd_data` shows the reset value. The default build uses bit i = policy code i and `RESET_VAL` = 12'h035.
- R2: Policy 0 (read/write): a write stores the written bit, and `rd_data` shows the stored value.
- R3: Policy 2 (write-only): a write stores the written bit in `field_q`, while `rd_data` always shows the bit's `RESET_VAL`.
- R4: Policy 3 (write 0 to clear): writing 0 clears the bit, and writing 1 leaves it unchanged.
- R5: Policy 4 (write 1 to clear): writing 1 clears the bit, and writing 0 leaves it unchanged.
- R6: Policy 5 (clear on write): any write clears the bit, whatever the written data.
- R7: Policy 6 (clear on read): a read returns the current value, and the bit is 0 from the next edge on. Writes have no effect.
- R8: Policy 7 (set on read): a read returns the current value, and the bit is 1 from the next edge on. Writes have no effect.
- R9: Policy 8 (software set): writing 1 sets the bit, and writing 0 has no effect.
- R10: Policy 9 (write once): only the first write after reset is stored, whatever its data. Later writes are ignored until the next reset.
- R11: Policy 10 (toggle): writing 1 inverts the bit, and writing 0 has no effect.
- R12: Policy 11 (trigger): writing 1 drives that bit of `evt_out` high for exactly the one cycle after the write edge. The stored and read value stay at `RESET_VAL`, and `hw_set` has no effect on the bit.
- R13: For every policy except trigger, `hw_set` forces the bit to 1 on the same edge. This wins over a software clear in the same cycle.
- R14: Policy 1 (read-only): writes and reads never change the bit. Only `hw_set` can change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | WIDTH | Read view of the field, combinational |
| hw_set | input | WIDTH | Per-bit hardware set request |
| field_q | output | WIDTH | Stored value of every bit |
| evt_out | output | WIDTH | Per-bit one-cycle trigger pulse |

## Verification
Writes and hardware sets are sampled on one rising edge and appear on `field_q` right after it. A trigger pulse on `evt_out` is high for the one cycle after that edge. `rd_data` is combinational, so a read's returned data is due in the same cycle as the strobe, and the read's side effect is due one edge later. The bench changes inputs on falling edges and samples `rd_data` shortly after the strobe is raised. It samples `field_q` and `evt_out` on the next falling edge, the first point where one register stage has settled. A reference model written from the requirements is stepped in lock with every operation.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

  localparam int POL_BITS = 4;

  typedef enum logic [POL_BITS-1:0] {
    POL_RW   = 4'd0,
    POL_RO   = 4'd1,
    POL_WO   = 4'd2,
    POL_W0C  = 4'd3,
    POL_W1C  = 4'd4,
    POL_WCLR = 4'd5,
    POL_RCLR = 4'd6,
    POL_RSET = 4'd7,
    POL_WSET = 4'd8,
    POL_ONCE = 4'd9,
    POL_TGL  = 4'd10,
    POL_TRIG = 4'd11
  } swpol_e;

  // Next value from software activity alone.
  function automatic logic sw_next(swpol_e p, logic cur, logic wr, logic wd,
                                   logic rd, logic locked);
    logic n;
    n = cur;
    case (p)
      POL_RW, POL_WO: if (wr) n = wd;
      POL_W0C:        if (wr && !wd) n = 1'b0;
      POL_W1C:        if (wr && wd) n = 1'b0;
      POL_WCLR:       if (wr) n = 1'b0;
      POL_RCLR:       if (rd) n = 1'b0;
      POL_RSET:       if (rd) n = 1'b1;
      POL_WSET:       if (wr && wd) n = 1'b1;
      POL_ONCE:       if (wr && !locked) n = wd;
      POL_TGL:        if (wr && wd) n = ~cur;
      default:        n = cur;
    endcase
    return n;
  endfunction

  // Hardware set overrides whatever software asked for.
  function automatic logic hw_merge(swpol_e p, logic sw_val, logic hs);
    return (hs && (p != POL_TRIG)) ? 1'b1 : sw_val;
  endfunction

  // What software sees on a read.
  function automatic logic rd_view(swpol_e p, logic cur, logic rst);
    return (p == POL_WO) ? rst : cur;
  endfunction

endpackage

// File: rtl/swreg_bit.sv
module swreg_bit
  import swreg_pkg::*;
#(
  parameter logic [POL_BITS-1:0] POL = 4'd0,
  parameter logic                RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_en,
  input  logic hw_set,
  output logic q,
  output logic evt
);

  localparam swpol_e PKIND = swpol_e'(POL);

  logic locked;
  logic sw_val;
  logic nxt;

  assign sw_val = sw_next(PKIND, q, wr_en, wr_bit, rd_en, locked);
  assign nxt    = hw_merge(PKIND, sw_val, hw_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= nxt;
  end

  generate
    if (PKIND == POL_ONCE) begin : g_lock
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     locked <= 1'b0;
        else if (wr_en) locked <= 1'b1;
      end
    end else begin : g_nolock
      assign locked = 1'b0;
    end

    if (PKIND == POL_TRIG) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= wr_en & wr_bit;
      end
    end else begin : g_noevt
      assign evt = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/swreg_rdmux.sv
module swreg_rdmux
  import swreg_pkg::*;
#(
  parameter int                         WIDTH     = 12,
  parameter logic [WIDTH*POL_BITS-1:0]  POLICY    = 48'hBA98_7654_3210,
  parameter logic [WIDTH-1:0]           RESET_VAL = 12'h035
) (
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rd_data
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_view
    localparam swpol_e PK = swpol_e'(POLICY[i*POL_BITS +: POL_BITS]);
    assign rd_data[i] = rd_view(PK, q[i], RESET_VAL[i]);
  end

endmodule

// File: rtl/swreg_field.sv
module swreg_field
  import swreg_pkg::*;
#(
  parameter int                         WIDTH     = 12,
  parameter logic [WIDTH*POL_BITS-1:0]  POLICY    = 48'hBA98_7654_3210,
  parameter logic [WIDTH-1:0]           RESET_VAL = 12'h035
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] hw_set,
  output logic [WIDTH-1:0] field_q,
  output logic [WIDTH-1:0] evt_out
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    swreg_bit #(
      .POL (POLICY[i*POL_BITS +: POL_BITS]),
      .RST (RESET_VAL[i])
    ) u_bit (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_bit (wr_data[i]),
      .rd_en  (rd_en),
      .hw_set (hw_set[i]),
      .q      (field_q[i]),
      .evt    (evt_out[i])
    );
  end

  swreg_rdmux #(
    .WIDTH     (WIDTH),
    .POLICY    (POLICY),
    .RESET_VAL (RESET_VAL)
  ) u_rd (
    .q       (field_q),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/swreg_field_chk.sv
module swreg_field_chk
  import swreg_pkg::*;
#(
  parameter int                         WIDTH     = 12,
  parameter logic [WIDTH*POL_BITS-1:0]  POLICY    = 48'hBA98_7654_3210,
  parameter logic [WIDTH-1:0]           RESET_VAL = 12'h035
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] hw_set,
  input logic [WIDTH-1:0] field_q,
  input logic [WIDTH-1:0] evt_out
);

  function automatic logic [WIDTH-1:0] mask_of(logic [POL_BITS-1:0] code);
    logic [WIDTH-1:0] m;
    for (int i = 0; i < WIDTH; i++) m[i] = (POLICY[i*POL_BITS +: POL_BITS] == code);
    return m;
  endfunction

  localparam logic [WIDTH-1:0] M_RO   = mask_of(4'd1);
  localparam logic [WIDTH-1:0] M_WO   = mask_of(4'd2);
  localparam logic [WIDTH-1:0] M_RCLR = mask_of(4'd6);
  localparam logic [WIDTH-1:0] M_RSET = mask_of(4'd7);
  localparam logic [WIDTH-1:0] M_TRIG = mask_of(4'd11);

  p_trig_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (field_q & M_TRIG) == (RESET_VAL & M_TRIG));

  p_evt_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt_out == ($past(wr_en) ? ($past(wr_data) & M_TRIG) : '0)));

  p_wo_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & M_WO) == (RESET_VAL & M_WO));

  p_hw_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & ~M_TRIG)) |=>
      ((field_q & $past(hw_set & ~M_TRIG)) == $past(hw_set & ~M_TRIG)));

  p_rclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((field_q & M_RCLR & ~$past(hw_set)) == '0));

  p_rset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((field_q & M_RSET) == M_RSET));

  p_ro_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(hw_set & M_RO)) |=> ((field_q & M_RO) == ($past(field_q) & M_RO)));

endmodule

bind swreg_field swreg_field_chk #(
  .WIDTH     (WIDTH),
  .POLICY    (POLICY),
  .RESET_VAL (RESET_VAL)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .hw_set  (hw_set),
  .field_q (field_q),
  .evt_out (evt_out)
);

// File: tb/sim_swreg_field.sv
`timescale 1ns/1ps
module sim_swreg_field;

  localparam int W = 12;
  localparam logic [W-1:0] RV = 12'h035;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [W-1:0] rd_data;
  logic [W-1:0] hw_set = '0;
  logic [W-1:0] field_q;
  logic [W-1:0] evt_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [W-1:0] m_q;
  logic         m_lock;

  always #2 clk = ~clk;

  swreg_field u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .hw_set(hw_set), .field_q(field_q), .evt_out(evt_out)
  );

  function automatic logic [W-1:0] m_read(logic [W-1:0] q);
    logic [W-1:0] r;
    r = q;
    r[2] = RV[2];
    return r;
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  // One bus/hardware cycle, model stepped alongside.
  task automatic step(string tag, logic wr, logic [W-1:0] wd, logic rd, logic [W-1:0] hs);
    logic [W-1:0] n;
    @(negedge clk);
    wr_en = wr; wr_data = wd; rd_en = rd; hw_set = hs;
    #1;
    if (rd) check(tag, "rd_data", rd_data, m_read(m_q));
    n = m_q;
    if (wr) n[0] = wd[0];
    if (wr) n[2] = wd[2];
    if (wr && !wd[3]) n[3] = 1'b0;
    if (wr && wd[4]) n[4] = 1'b0;
    if (wr) n[5] = 1'b0;
    if (rd) n[6] = 1'b0;
    if (rd) n[7] = 1'b1;
    if (wr && wd[8]) n[8] = 1'b1;
    if (wr && !m_lock) n[9] = wd[9];
    if (wr && wd[10]) n[10] = ~m_q[10];
    n = n | (hs & ~12'h800);
    if (wr) m_lock = 1'b1;
    m_q = n;
    @(negedge clk);
    wr_en = 0; wr_data = '0; rd_en = 0; hw_set = '0;
    check(tag, "field_q", field_q, m_q);
    check(tag, "evt_out", evt_out, (wr && wd[11]) ? 12'h800 : 12'h000);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_q = RV; m_lock = 0;
    #1;
    check(tag, "field_q", field_q, RV);
    check(tag, "evt_out", evt_out, '0);
    check(tag, "rd_data", rd_data, m_read(RV));
  endtask

  task automatic t_reset_r1();   do_reset("R1"); endtask

  task automatic t_once_r10();
    step("R10", 1, 12'h200, 0, '0);
    step("R10", 1, 12'h000, 0, '0);
    check("R10", "bit9", {11'd0, field_q[9]}, 12'h001);
    do_reset("R10");
    step("R10", 1, 12'h000, 0, '0);
    step("R10", 1, 12'h200, 0, '0);
    check("R10", "bit9", {11'd0, field_q[9]}, 12'h000);
  endtask

  task automatic t_rw_r2();
    step("R2", 1, 12'h001, 0, '0);
    step("R2", 0, '0, 1, '0);
    step("R2", 1, 12'h000, 1, '0);
  endtask

  task automatic t_wo_r3();
    step("R3", 1, 12'h004, 1, '0);
    step("R3", 1, 12'h000, 0, '0);
    step("R3", 0, '0, 1, '0);
  endtask

  task automatic t_w0c_r4();
    step("R4", 0, '0, 0, 12'h008);
    step("R4", 1, 12'h008, 0, '0);
    step("R4", 1, 12'h000, 0, '0);
  endtask

  task automatic t_w1c_r5();
    step("R5", 0, '0, 0, 12'h010);
    step("R5", 1, 12'h000, 0, '0);
    step("R5", 1, 12'h010, 0, '0);
  endtask

  task automatic t_wc_r6();
    step("R6", 0, '0, 0, 12'h020);
    step("R6", 1, 12'h020, 0, '0);
    step("R6", 0, '0, 0, 12'h020);
    step("R6", 1, 12'h000, 0, '0);
  endtask

  task automatic t_rclr_r7();
    step("R7", 1, 12'h040, 0, '0);
    step("R7", 0, '0, 0, 12'h040);
    step("R7", 1, 12'h000, 0, '0);
    step("R7", 0, '0, 1, '0);
    step("R7", 0, '0, 1, '0);
  endtask

  task automatic t_rset_r8();
    step("R8", 1, 12'h080, 0, '0);
    step("R8", 0, '0, 1, '0);
    step("R8", 1, 12'h000, 1, '0);
  endtask

  task automatic t_wset_r9();
    step("R9", 1, 12'h000, 0, '0);
    step("R9", 1, 12'h100, 0, '0);
    step("R9", 1, 12'h000, 0, '0);
  endtask

  task automatic t_tgl_r11();
    step("R11", 1, 12'h400, 0, '0);
    step("R11", 1, 12'h000, 0, '0);
    step("R11", 1, 12'h400, 0, '0);
  endtask

  task automatic t_trig_r12();
    step("R12", 1, 12'h800, 1, 12'h800);
    step("R12", 0, '0, 1, '0);
    step("R12", 1, 12'h000, 0, '0);
  endtask

  task automatic t_hw_r13();
    step("R13", 1, 12'h010, 0, 12'h010);
    step("R13", 1, 12'h000, 0, 12'h028);
    step("R13", 0, '0, 1, 12'h040);
    step("R13", 1, 12'hFFF, 1, 12'hFFF);
  endtask

  task automatic t_ro_r14();
    do_reset("R14");
    step("R14", 1, 12'hFFF, 1, '0);
    step("R14", 0, '0, 0, 12'h002);
    step("R14", 1, 12'h000, 1, '0);
  endtask

  initial begin
    m_q = RV; m_lock = 0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_once_r10();
    t_rw_r2();
    t_wo_r3();
    t_w0c_r4();
    t_w1c_r5();
    t_wc_r6();
    t_rclr_r7();
    t_rset_r8();
    t_wset_r9();
    t_tgl_r11();
    t_trig_r12();
    t_hw_r13();
    t_ro_r14();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got %0d exp 0", 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule